// File: doc/BRIEF.md
# Parallel Port Interrupt Flag Controller

This block gathers the interrupt events of a two-port parallel I/O unit and drives one active-low interrupt request. Each port (A and B) has two control lines. Each line has a two-flop synchronizer followed by an edge detector, and each line has its own edge polarity. Three more sources arrive as single-cycle pulses: two timer-underflow events and one shift-register event that fires when eight bits are complete. Each of the seven sources owns one sticky flag. A flag is raised by its event and cleared by software. For the control lines, a flag can also be cleared by an access to the data register of its port.

Software reaches the block through a small register bus. Reads are combinational on `addr`, and writes take effect at the clock edge. The flag register can be read whether or not interrupts are enabled, so events can be polled while they are masked. The enable register uses a set/clear write format. A line-control register selects, for each line, the edge that is sensed and whether a port data access clears its flag. Two further addresses serve only as the port A and port B data-access strobes. The port data latches, timers and shift register live outside this block.

The block has no data stream, so there is no valid/ready handshake. Every pin is a plain control or status signal, and the bus never applies back-pressure.

Top module: `pio_irq_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, all flags, all enable bits and the line-control register are zero. `irq_n` is 1, the flag register reads 0x00 and the enable register reads 0x80.
- R2: Address 0 reads the flag register.
  - Bit 0 is CA1, bit 1 is CA2, bit 2 is CB1, bit 3 is CB2, bit 4 is timer 0, bit 5 is timer 1 and bit 6 is the shift event.
  - Bit 7 reads 1 exactly when some flag and its enable bit are both set.
  - Flags read back even when they are masked.
- R3: Writing address 0 clears each flag whose `wdata` bit is 1 and leaves the flags under 0 bits unchanged. The change takes effect at that clock edge.
- R4: Writing address 1 updates the enable register.
  - With `wdata[7]`=1, the enable bits selected by `wdata[6:0]` are set.
  - With `wdata[7]`=0, those bits are cleared.
  - The enable register reads back with bit 7 = 1.
- R5: `irq_n` is 0 exactly when some flag and its matching enable bit are both 1.
- R6: Line control bit 0 sets the CA1 polarity and bit 4 sets the CB1 polarity: 0 senses a falling edge and 1 senses a rising edge. A sensed edge raises its flag at the third rising clock edge at which the new input level is present, counting the first such edge. The other edge direction is ignored.
- R7: Any read or write at address 3 (port A access) clears CA1, and any read or write at address 4 (port B access) clears CB1. An access to one port does not clear the other port's flags.
- R8: CA2 takes a 3-bit code from line control bits [3:1], and CB2 takes one from bits [7:5].
  - Code bit 1 sets the polarity: 0 is falling, 1 is rising.
  - Code bit 0 selects independent mode.
  - Code bit 2 = 1 disables edge sensing for that line.
  - Code 001 is falling-edge independent mode.
- R9: In independent mode (code bit 0 = 1), a port access does not clear the CA2/CB2 flag. With code bit 0 = 0, the matching port access clears it.
- R10: A one-cycle pulse on `tmr0_evt`, `tmr1_evt` or `sr_evt` sets flag bit 4, 5 or 6 respectively at the next clock edge.
- R11: When a setting event and a clear (a port access or a flag write) hit the same flag in the same cycle, the flag ends up set.
- R12: Address 2 reads back the line-control register as written. Reads at addresses 3 to 7 return 0x00, and a read at address 0 has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register select |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; only matters at the port access addresses |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register selected by `addr` |
| ca1 | input | 1 | Port A control line 1 |
| ca2 | input | 1 | Port A control line 2 |
| cb1 | input | 1 | Port B control line 1 |
| cb2 | input | 1 | Port B control line 2 |
| tmr0_evt | input | 1 | Timer 0 underflow pulse |
| tmr1_evt | input | 1 | Timer 1 underflow pulse |
| sr_evt | input | 1 | Shift-register eight-bit-done pulse |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets the corner cases of this block:
- The exact cycle at which a synchronized edge lands. A synchronizer one stage short or long shows the flag a cycle early or late.
- Edges of the opposite polarity. A wrong polarity decode raises flags on the wrong edge.
- Independent mode, where a port access must leave the CA2/CB2 flag in place. A design that ignores the mode loses a pending event before it is polled.
- Cross-port accesses. Crossed clear wiring wipes the other port's flags.
- An edge or timer pulse that coincides with a clear. A design with clear priority silently drops that event.
- The disabled CA2/CB2 codes, which must sense nothing.

// File: rtl/pio_irq_pkg.sv
package pio_irq_pkg;
  localparam int NUM_SRC   = 7;
  localparam int NUM_LINES = 4;
  localparam int DW        = 8;
  localparam int AW        = 3;

  localparam int SRC_CA1   = 0;
  localparam int SRC_CA2   = 1;
  localparam int SRC_CB1   = 2;
  localparam int SRC_CB2   = 3;
  localparam int SRC_TMR0  = 4;
  localparam int SRC_TMR1  = 5;
  localparam int SRC_SHIFT = 6;

  localparam logic [AW-1:0] REG_FLAG = 3'd0;
  localparam logic [AW-1:0] REG_ENA  = 3'd1;
  localparam logic [AW-1:0] REG_LCTL = 3'd2;
  localparam logic [AW-1:0] REG_PA   = 3'd3;
  localparam logic [AW-1:0] REG_PB   = 3'd4;

  typedef struct packed {
    logic sense_en;
    logic rise_sel;
  } line_cfg_t;
endpackage

// File: rtl/pio_edge_sense.sv
module pio_edge_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  pio_irq_pkg::line_cfg_t cfg,
  output logic edge_hit
);
  localparam int LAST = SYNC_STAGES - 1;

  logic stage [SYNC_STAGES];
  logic prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) stage[g] <= 1'b0;
      else if (g == 0) stage[g] <= line_in;
      else stage[g] <= stage[(g == 0) ? 0 : g - 1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stage[LAST];
  end

  logic rise_seen, fall_seen;
  always_comb begin
    rise_seen = stage[LAST] & ~prev_q;
    fall_seen = ~stage[LAST] & prev_q;
    edge_hit  = cfg.sense_en & (cfg.rise_sel ? rise_seen : fall_seen);
  end
endmodule

// File: rtl/pio_flag_bank.sv
module pio_flag_bank #(
  parameter int NSRC = pio_irq_pkg::NUM_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  input  logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] flag_q,
  output logic            irq_pend
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (set_vec[i]) flag_q[i] <= 1'b1;
      else if (clr_vec[i]) flag_q[i] <= 1'b0;
    end
  end

  assign irq_pend = |(flag_q & en_q);
endmodule

// File: rtl/pio_reg_if.sv
module pio_reg_if
  import pio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [DW-1:0]      wdata,
  input  logic [NUM_SRC-1:0] flag_q,
  input  logic               irq_pend,
  output logic [NUM_SRC-1:0] en_q,
  output logic [DW-1:0]      lctl_q,
  output logic [NUM_SRC-1:0] wr_clr,
  output logic               pa_acc,
  output logic               pb_acc,
  output logic [DW-1:0]      rdata
);
  logic any_acc;
  assign any_acc = wr_en | rd_en;
  assign pa_acc  = any_acc && (addr == REG_PA);
  assign pb_acc  = any_acc && (addr == REG_PB);
  assign wr_clr  = (wr_en && addr == REG_FLAG) ? wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      lctl_q <= '0;
    end else if (wr_en) begin
      if (addr == REG_ENA) begin
        if (wdata[DW-1]) en_q <= en_q | wdata[NUM_SRC-1:0];
        else             en_q <= en_q & ~wdata[NUM_SRC-1:0];
      end
      if (addr == REG_LCTL) lctl_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      REG_FLAG: rdata = {irq_pend, flag_q};
      REG_ENA:  rdata = {1'b1, en_q};
      REG_LCTL: rdata = lctl_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl
  import pio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ca1,
  input  logic          ca2,
  input  logic          cb1,
  input  logic          cb2,
  input  logic          tmr0_evt,
  input  logic          tmr1_evt,
  input  logic          sr_evt,
  output logic          irq_n
);
  logic [NUM_SRC-1:0]   en_q, flag_q, wr_clr, set_vec, clr_vec;
  logic [DW-1:0]        lctl_q;
  logic                 pa_acc, pb_acc, irq_pend;
  logic [NUM_LINES-1:0] line_raw, line_hit;
  line_cfg_t            cfg [NUM_LINES];
  logic [1:0]           indep;
  logic [1:0]           port_acc;

  assign line_raw = {cb2, cb1, ca2, ca1};
  assign port_acc = {pb_acc, pa_acc};

  pio_reg_if u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .flag_q(flag_q), .irq_pend(irq_pend), .en_q(en_q),
    .lctl_q(lctl_q), .wr_clr(wr_clr), .pa_acc(pa_acc), .pb_acc(pb_acc),
    .rdata(rdata)
  );

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [3:0] nib;
    assign nib = lctl_q[4*p +: 4];
    assign cfg[2*p].sense_en   = 1'b1;
    assign cfg[2*p].rise_sel   = nib[0];
    assign cfg[2*p+1].sense_en = ~nib[3];
    assign cfg[2*p+1].rise_sel = nib[2];
    assign indep[p]            = nib[1];
    assign clr_vec[2*p]        = wr_clr[2*p] | port_acc[p];
    assign clr_vec[2*p+1]      = wr_clr[2*p+1] | (port_acc[p] & ~indep[p]);
  end

  assign clr_vec[NUM_SRC-1:NUM_LINES] = wr_clr[NUM_SRC-1:NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    pio_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_es (
      .clk(clk), .rst_n(rst_n), .line_in(line_raw[i]), .cfg(cfg[i]),
      .edge_hit(line_hit[i])
    );
  end

  assign set_vec = {sr_evt, tmr1_evt, tmr0_evt, line_hit};

  pio_flag_bank #(.NSRC(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .en_q(en_q), .flag_q(flag_q), .irq_pend(irq_pend)
  );

  assign irq_n = ~irq_pend;
endmodule

// File: rtl/pio_irq_chk.sv
module pio_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic       wdata_b5,
  input logic       rdata_b7,
  input logic       irq_n,
  input logic       tmr0_evt,
  input logic       tmr1_evt,
  input logic       sr_evt,
  input logic [6:0] flag_q,
  input logic [6:0] en_q,
  input logic [3:0] line_hit
);
  AST_BIT7_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd0) |-> (rdata_b7 == !irq_n)); // R2

  AST_ENA_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd1) |-> rdata_b7); // R4

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 7'd0) |-> irq_n); // R5

  AST_TMR0_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_evt |=> flag_q[4]); // R10

  AST_SHIFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sr_evt |=> flag_q[6]); // R10

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && wdata_b5 && !tmr1_evt) |=> !flag_q[5]); // R3

  AST_CA1_PORT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && addr == 3'd3 && !line_hit[0]) |=> !flag_q[0]); // R7

  AST_CB1_PORT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && addr == 3'd4 && !line_hit[2]) |=> !flag_q[2]); // R7

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_hit) |=> ((flag_q[3:0] & $past(line_hit)) == $past(line_hit))); // R11
endmodule

bind pio_irq_ctrl pio_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata_b5(wdata[5]), .rdata_b7(rdata[7]), .irq_n(irq_n),
  .tmr0_evt(tmr0_evt), .tmr1_evt(tmr1_evt), .sr_evt(sr_evt),
  .flag_q(flag_q), .en_q(en_q), .line_hit(line_hit)
);

// File: tb/sim_pio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_pio_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic ca1 = 0, ca2 = 0, cb1 = 0, cb2 = 0;
  logic tmr0_evt = 0, tmr1_evt = 0, sr_evt = 0;
  logic irq_n;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pio_irq_ctrl u0 (.*);

  // behavioural reference model
  logic [6:0] mflag = 0, men = 0;
  logic [7:0] mctl = 0;
  logic [3:0] hist [$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return {|(mflag & men), mflag};
      3'd1: return {1'b1, men};
      3'd2: return mctl;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mflag = 0; men = 0; mctl = 0;
      hist = {4'h0, 4'h0, 4'h0, 4'h0};
    end else begin
      logic [6:0] setv, clrv;
      logic pa, pb;
      setv = {sr_evt, tmr1_evt, tmr0_evt, 4'h0};
      for (int i = 0; i < 4; i++) begin
        logic [3:0] nib;
        logic sense, rise, c, o;
        nib = mctl[4*(i/2) +: 4];
        sense = (i % 2 == 0) ? 1'b1 : !nib[3];
        rise  = (i % 2 == 0) ? nib[0] : nib[2];
        c = hist[1][i];
        o = hist[2][i];
        setv[i] = sense && (rise ? (c && !o) : (!c && o));
      end
      pa = (wr_en || rd_en) && addr == 3'd3;
      pb = (wr_en || rd_en) && addr == 3'd4;
      clrv = 0;
      clrv[0] = pa;
      clrv[1] = pa && !mctl[1];
      clrv[2] = pb;
      clrv[3] = pb && !mctl[5];
      if (wr_en && addr == 3'd0) clrv = clrv | wdata[6:0];
      mflag = (mflag & ~clrv) | setv;
      if (wr_en && addr == 3'd1) men = wdata[7] ? (men | wdata[6:0]) : (men & ~wdata[6:0]);
      if (wr_en && addr == 3'd2) mctl = wdata;
      hist.push_front({cb2, cb1, ca2, ca1});
      void'(hist.pop_back());
    end
    #5;
    chk("R5 irq_n per-cycle", irq_n, ~|(mflag & men));
    chk("R12 rdata per-cycle", rdata, exp_rd(addr));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic bus_wr(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic port_rd(logic [2:0] a);
    addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; addr = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    cyc(3);
    peek(0, v); chk("R1 flags in reset", v, 8'h00);
    chk("R1 irq_n in reset", irq_n, 1);
    rst_n = 1;
    cyc(2);
    peek(0, v); chk("R1 flags after reset", v, 8'h00);
    peek(1, v); chk("R1 enable after reset", v, 8'h80);
    peek(2, v); chk("R1 lctl after reset", v, 8'h00);

    // R10 timer pulse, masked but readable (R2)
    tmr0_evt = 1; cyc(1); tmr0_evt = 0;
    peek(0, v); chk("R10 tmr0 flag masked readable", v, 8'h10);
    chk("R5 masked irq_n", irq_n, 1);
    sr_evt = 1; cyc(1); sr_evt = 0;
    peek(0, v); chk("R10 shift flag", v, 8'h50);
    bus_wr(0, 8'h40);

    // R4 enable set/clear
    bus_wr(1, 8'h90);
    peek(1, v); chk("R4 enable set", v, 8'h90);
    peek(0, v); chk("R2 bit7 pending", v, 8'h90);
    chk("R5 irq asserted", irq_n, 0);
    bus_wr(1, 8'h10);
    peek(1, v); chk("R4 enable clear", v, 8'h80);
    chk("R5 irq released", irq_n, 1);

    // R3 write-one-to-clear
    bus_wr(0, 8'h10);
    peek(0, v); chk("R3 clear by 1", v, 8'h00);
    tmr1_evt = 1; cyc(1); tmr1_evt = 0;
    bus_wr(0, 8'h00);
    peek(0, v); chk("R3 zero write keeps", v, 8'h20);
    bus_wr(0, 8'h20);
    peek(0, v); chk("R3 clear tmr1", v, 8'h00);

    // R6 CA1 falling by default, latency
    ca1 = 1; cyc(4);
    peek(0, v); chk("R6 CA1 rising ignored", v, 8'h00);
    ca1 = 0; cyc(2);
    peek(0, v); chk("R6 CA1 not yet after 2", v, 8'h00);
    cyc(1);
    peek(0, v); chk("R6 CA1 falling at 3rd edge", v, 8'h01);

    // R7 port clears
    port_rd(3);
    peek(0, v); chk("R7 port A read clears CA1", v, 8'h00);
    bus_wr(2, 8'h01);
    ca1 = 1; cyc(3);
    peek(0, v); chk("R6 CA1 rising mode", v, 8'h01);
    port_rd(4);
    peek(0, v); chk("R7 port B leaves CA1", v, 8'h01);
    bus_wr(3, 8'hA5);
    peek(0, v); chk("R7 port A write clears CA1", v, 8'h00);

    // R8 R9 CA2 modes
    bus_wr(2, 8'h02);
    ca2 = 1; cyc(4);
    peek(0, v); chk("R8 CA2 code001 rising ignored", v, 8'h00);
    ca2 = 0; cyc(3);
    peek(0, v); chk("R8 CA2 code001 falling", v, 8'h02);
    port_rd(3);
    peek(0, v); chk("R9 independent survives port A", v, 8'h02);
    bus_wr(1, 8'h82);
    chk("R5 CA2 enabled irq", irq_n, 0);
    bus_wr(1, 8'h02);
    bus_wr(0, 8'h02);
    bus_wr(2, 8'h00);
    ca2 = 1; cyc(4); ca2 = 0; cyc(3);
    peek(0, v); chk("R8 CA2 code000 falling", v, 8'h02);
    port_rd(3);
    peek(0, v); chk("R9 code000 cleared by port A", v, 8'h00);
    bus_wr(2, 8'h04);
    ca2 = 1; cyc(3);
    peek(0, v); chk("R8 CA2 code010 rising", v, 8'h02);
    bus_wr(3, 8'h00);
    peek(0, v); chk("R9 code010 cleared by port A", v, 8'h00);
    bus_wr(2, 8'h08);
    ca2 = 0; cyc(4); ca2 = 1; cyc(4);
    peek(0, v); chk("R8 CA2 code100 no sensing", v, 8'h00);

    // CB side
    bus_wr(2, 8'h10);
    cb1 = 1; cyc(3);
    peek(0, v); chk("R6 CB1 rising", v, 8'h04);
    port_rd(3);
    peek(0, v); chk("R7 port A leaves CB1", v, 8'h04);
    port_rd(4);
    peek(0, v); chk("R7 port B clears CB1", v, 8'h00);
    bus_wr(2, 8'h20);
    cb2 = 1; cyc(4); cb2 = 0; cyc(3);
    peek(0, v); chk("R8 CB2 code001 falling", v, 8'h08);
    port_rd(4);
    peek(0, v); chk("R9 CB2 independent survives port B", v, 8'h08);
    bus_wr(0, 8'h08);
    peek(0, v); chk("R3 clear CB2", v, 8'h00);

    // R11 set wins
    addr = 0; wdata = 8'h10; wr_en = 1; tmr0_evt = 1;
    cyc(1); wr_en = 0; tmr0_evt = 0;
    peek(0, v); chk("R11 tmr0 beats flag write", v, 8'h10);
    bus_wr(0, 8'h10);
    bus_wr(2, 8'h00);
    ca1 = 0; cyc(2);
    addr = 3; rd_en = 1; cyc(1); rd_en = 0;
    peek(0, v); chk("R11 CA1 edge beats port A access", v, 8'h01);
    port_rd(3);
    peek(0, v); chk("R7 CA1 cleared afterwards", v, 8'h00);

    // R12 map
    bus_wr(2, 8'h5A);
    peek(2, v); chk("R12 lctl readback", v, 8'h5A);
    peek(5, v); chk("R12 unused address", v, 8'h00);
    peek(3, v); chk("R12 port A address reads 0", v, 8'h00);
    cyc(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule